// File: doc/BRIEF.md
# Waveform Channel Configuration Registers

This block holds the configuration state of one waveform generator channel. Configuration writes arrive on a single port, each carrying a register address and a 32-bit data word. Each write is taken as occurring on the coarse clock cycle in which its strobe is high. The block stores the following state:
- the spline pacing divider, with a counter value that software can load;
- three auto-clear flags, one for each phase accumulator;
- the in-phase and quadrature enable flags;
- four signed saturation bounds, for the up-converter input and for the final output.

Using the divider, the block makes one spline-advance strobe, and every interpolator in the channel shares it. The phase accumulators are not paced by this strobe and step on every cycle.

Configuration accesses must be spaced apart. A write that lands fewer than the minimum number of cycles after the last accepted write is refused. The refused write leaves every register unchanged and raises a one-cycle collision pulse. Writes to unmapped addresses are discarded without any error.

Top module: `wfm_cfg_regs`

## Requirements
- R1: After reset the state is: divider 0, counter 0, clear flags 3'b111, in-phase enable 1, quadrature enable 0, both upper bounds +32767 and both lower bounds -32767.
- R2: Address map: 0 is the divider, 1 the clear flags, 2 the I/Q enables, 3 the up-converter upper bound, 4 the up-converter lower bound, 5 the output upper bound, 6 the output lower bound, and 7 is unmapped.
- R3: A write to address 0 takes the divider from data bits 15:0 and loads the pacing counter from data bits 31:16.
- R4: With the divider at d and no writes, the strobe is high on exactly one cycle in every d+1. When d is 0 it is high on every cycle.
- R5: In the cycle after a divider write, the strobe is high if the loaded count is greater than or equal to d. Otherwise the count increases by one per cycle until it reaches d, and the strobe is high in that cycle. After each strobe the count restarts from 0.
- R6: A write to address 1 stores data bits 2:0 as the three clear flags (bit 0 for accumulator 0, up to bit 2 for accumulator 2).
- R7: A write to address 2 stores data bit 0 as the in-phase enable and data bit 1 as the quadrature enable.
- R8: Writes to addresses 3 to 6 store data bits 15:0 as a signed two's-complement bound. The upper data bits are ignored.
- R9: A write to a mapped address one or two cycles after the last accepted write is a collision. The collision output is high for the single cycle after it.
- R10: A colliding write changes no register. The spacing window is measured from the last accepted write only, so a write three cycles after an accepted write is accepted even when collisions came in between.
- R11: A write to address 7 changes no output, raises no collision and does not restart the spacing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data word |
| div_o | output | 16 | Current spline pacing divider |
| spline_stb_o | output | 1 | Shared spline-advance strobe |
| clr_o | output | 3 | Accumulator auto-clear flags |
| i_en_o | output | 1 | In-phase enable |
| q_en_o | output | 1 | Quadrature enable |
| duc_hi_o | output | 16 | Signed up-converter upper bound |
| duc_lo_o | output | 16 | Signed up-converter lower bound |
| out_hi_o | output | 16 | Signed output upper bound |
| out_lo_o | output | 16 | Signed output lower bound |
| collide_o | output | 1 | One-cycle pulse after a refused write |

## Verification
The assertions assume that each access is a single-cycle strobe with a stable address. They also assume that nothing other than this port changes the registers, so any change of an output is traced back to an accepted write in the cycle before. The stimulus drives every access as a one-cycle pulse on the falling clock edge. It spaces ordinary writes exactly three cycles apart, so the only collisions are the ones placed on purpose at gaps of one and two cycles. The divider sweep writes each divider and counter pair once. It then leaves the port idle for long enough to observe several whole strobe periods.

// File: rtl/wcfg_pkg.sv
// Shared address codes for the channel configuration register file.
// Assumes a 3-bit address; codes above OMIN_A are unmapped.
package wcfg_pkg;
    localparam int DIV_A  = 0;
    localparam int CLR_A  = 1;
    localparam int IQ_A   = 2;
    localparam int DHI_A  = 3;
    localparam int DLO_A  = 4;
    localparam int OHI_A  = 5;
    localparam int OLO_A  = 6;
    localparam int LAST_A = OLO_A;
endpackage

// File: rtl/wcfg_spacing.sv
// Access-spacing guard: accepts a request only when at least MIN_GAP cycles
// have passed since the last accepted one, and pulses a collision flag the
// cycle after a refused request. Assumes req is already qualified by address.
module wcfg_spacing #(
    parameter int MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic collide_q
);
    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(MIN_GAP);

    logic [GAP_W-1:0] gap_q;

    // a request is accepted only once the window from the last accept has closed
    always_comb accept = req && (gap_q >= GAP_FULL);

    // track cycles since the last accepted access, saturating at the minimum
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= GAP_FULL;
        else if (accept)
            gap_q <= GAP_W'(1);
        else if (gap_q < GAP_FULL)
            gap_q <= gap_q + GAP_W'(1);
    end

    // flag a refused request for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            collide_q <= 1'b0;
        else
            collide_q <= req && !accept;
    end
endmodule

// File: rtl/wcfg_pacer.sv
// Spline pacing counter: raises the strobe whenever the count has reached the
// divider, then restarts from zero. The count can be loaded directly.
// Assumes load and the new divider take effect on the same edge.
module wcfg_pacer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             stb
);
    logic [DIV_W-1:0] cnt_q;

    // strobe when the count has reached (or been loaded past) the divider
    always_comb stb = (cnt_q >= div);

    // count up, restart after a strobe, or take a loaded value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (stb)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/wcfg_bank.sv
// Register bank: stores divider, clear flags, I/Q enables and four signed
// bounds from accepted writes. Assumes 'fire' is already spacing-qualified.
module wcfg_bank #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int LIM_W  = 16,
    parameter int NCLR   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       data,
    output logic [DIV_W-1:0]        div_q,
    output logic [NCLR-1:0]         clr_q,
    output logic                    i_en_q,
    output logic                    q_en_q,
    output logic signed [LIM_W-1:0] lim_q [4]
);
    import wcfg_pkg::*;

    localparam logic signed [LIM_W-1:0] FULL_POS = LIM_W'((1 << (LIM_W - 1)) - 1);
    localparam logic signed [LIM_W-1:0] FULL_NEG = -FULL_POS;

    // divider field update
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (fire && addr == ADDR_W'(DIV_A))
            div_q <= data[DIV_W-1:0];
    end

    // accumulator clear flags update
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_q <= '1;
        else if (fire && addr == ADDR_W'(CLR_A))
            clr_q <= data[NCLR-1:0];
    end

    // I/Q enable flags update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_en_q <= 1'b1;
            q_en_q <= 1'b0;
        end else if (fire && addr == ADDR_W'(IQ_A)) begin
            i_en_q <= data[0];
            q_en_q <= data[1];
        end
    end

    // four bounds: even slots are upper, odd slots are lower
    for (genvar g = 0; g < 4; g++) begin : g_lim
        localparam logic signed [LIM_W-1:0] INIT = (g % 2 == 0) ? FULL_POS : FULL_NEG;
        // bound register g update
        always_ff @(posedge clk) begin
            if (!rst_n)
                lim_q[g] <= INIT;
            else if (fire && addr == ADDR_W'(DHI_A + g))
                lim_q[g] <= data[LIM_W-1:0];
        end
    end
endmodule

// File: rtl/wfm_cfg_regs.sv
// Top of the channel configuration register file: qualifies writes by
// address, enforces access spacing and drives the shared spline strobe.
// Assumes one write strobe per access on the coarse clock.
module wfm_cfg_regs #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 16,
    parameter int LIM_W   = 16,
    parameter int NCLR    = 3,
    parameter int MIN_GAP = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DIV_W-1:0]        div_o,
    output logic                    spline_stb_o,
    output logic [NCLR-1:0]         clr_o,
    output logic                    i_en_o,
    output logic                    q_en_o,
    output logic signed [LIM_W-1:0] duc_hi_o,
    output logic signed [LIM_W-1:0] duc_lo_o,
    output logic signed [LIM_W-1:0] out_hi_o,
    output logic signed [LIM_W-1:0] out_lo_o,
    output logic                    collide_o
);
    import wcfg_pkg::*;

    logic mapped, fire, cnt_load;
    logic signed [LIM_W-1:0] lim [4];

    // only mapped addresses take part in spacing and storage
    always_comb begin
        mapped   = wr_en && (wr_addr <= ADDR_W'(LAST_A));
        cnt_load = fire && (wr_addr == ADDR_W'(DIV_A));
    end

    wcfg_spacing #(.MIN_GAP(MIN_GAP)) u_space (
        .clk(clk), .rst_n(rst_n), .req(mapped),
        .accept(fire), .collide_q(collide_o)
    );

    wcfg_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
        .LIM_W(LIM_W), .NCLR(NCLR)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .fire(fire), .addr(wr_addr), .data(wr_data),
        .div_q(div_o), .clr_q(clr_o), .i_en_q(i_en_o), .q_en_q(q_en_o),
        .lim_q(lim)
    );

    wcfg_pacer #(.DIV_W(DIV_W)) u_pace (
        .clk(clk), .rst_n(rst_n), .div(div_o), .load(cnt_load),
        .load_val(wr_data[2*DIV_W-1:DIV_W]), .stb(spline_stb_o)
    );

    // expose bound slots as named ports
    always_comb begin
        duc_hi_o = lim[0];
        duc_lo_o = lim[1];
        out_hi_o = lim[2];
        out_lo_o = lim[3];
    end
endmodule

// File: rtl/wfm_cfg_regs_chk.sv
// Checker for wfm_cfg_regs: relates the write port to register outputs,
// the collision pulse and the shared strobe.
module wfm_cfg_regs_chk #(
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 16,
    parameter int LIM_W  = 16,
    parameter int NCLR   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [DIV_W-1:0]        div_o,
    input logic                    spline_stb_o,
    input logic [NCLR-1:0]         clr_o,
    input logic                    i_en_o,
    input logic                    q_en_o,
    input logic signed [LIM_W-1:0] duc_hi_o,
    input logic signed [LIM_W-1:0] out_lo_o,
    input logic                    collide_o
);
    // R9
    collide_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide_o |-> $past(wr_en));

    // R10
    collide_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide_o |-> ($stable(clr_o) && $stable(i_en_o) && $stable(q_en_o)
                       && $stable(div_o) && $stable(duc_hi_o) && $stable(out_lo_o)));

    // R11
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(7)) |=> !collide_o);

    // R4
    div_zero_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_o == '0) |-> spline_stb_o);

    // R4
    no_back_to_back_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spline_stb_o && div_o != '0) |=> (!spline_stb_o || $past(wr_en)));

    // R9
    single_cycle_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collide_o && !$past(wr_en, 1)) |-> 1'b0);
endmodule

bind wfm_cfg_regs wfm_cfg_regs_chk #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .LIM_W(LIM_W), .NCLR(NCLR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .div_o(div_o), .spline_stb_o(spline_stb_o), .clr_o(clr_o),
    .i_en_o(i_en_o), .q_en_o(q_en_o), .duc_hi_o(duc_hi_o),
    .out_lo_o(out_lo_o), .collide_o(collide_o)
);

// File: tb/wfm_cfg_regs_test.sv
module wfm_cfg_regs_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] div_o;
    logic spline_stb_o;
    logic [2:0] clr_o;
    logic i_en_o, q_en_o, collide_o;
    logic signed [15:0] duc_hi_o, duc_lo_o, out_hi_o, out_lo_o;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wfm_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_o(div_o), .spline_stb_o(spline_stb_o),
        .clr_o(clr_o), .i_en_o(i_en_o), .q_en_o(q_en_o),
        .duc_hi_o(duc_hi_o), .duc_lo_o(duc_lo_o), .out_hi_o(out_hi_o),
        .out_lo_o(out_lo_o), .collide_o(collide_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one-cycle write; returns at the falling edge after the capturing edge
    task automatic wr(input int addr, input logic [31:0] data);
        wr_en = 1'b1;
        wr_addr = 3'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 div", int'(div_o), 0);
        chk("R1 clr", int'(clr_o), 7);
        chk("R1 i_en", int'(i_en_o), 1);
        chk("R1 q_en", int'(q_en_o), 0);
        chk("R1 duc_hi", int'(duc_hi_o), 32767);
        chk("R1 duc_lo", int'(duc_lo_o), -32767);
        chk("R1 out_hi", int'(out_hi_o), 32767);
        chk("R1 out_lo", int'(out_lo_o), -32767);
        chk("R1 collide", int'(collide_o), 0);
        chk("R4 stb at div 0", int'(spline_stb_o), 1);

        // R6 / R7 / R2 sweep of flag registers
        for (int v = 0; v < 8; v++) begin
            wr(1, 32'hFFFF_FFF8 | 32'(v));
            chk("R6 clr", int'(clr_o), v);
            chk("R9 no collide", int'(collide_o), 0);
            idle(2);
        end
        for (int v = 0; v < 4; v++) begin
            wr(2, 32'(v));
            chk("R7 i_en", int'(i_en_o), v & 1);
            chk("R7 q_en", int'(q_en_o), (v >> 1) & 1);
            idle(2);
        end

        // R8 bounds with junk in the upper bits
        for (int s = 0; s < 4; s++) begin
            int val;
            val = -32768 + s * 12345;
            wr(3 + s, {16'hA5C3, 16'(val)});
            chk("R8 duc_hi", int'(duc_hi_o), s == 0 ? val : (s > 0 ? -32768 : 0));
            chk("R8 duc_lo", int'(duc_lo_o), s == 1 ? val : (s > 1 ? -32768 + 12345 : -32767));
            chk("R8 out_hi", int'(out_hi_o), s == 2 ? val : (s > 2 ? -32768 + 24690 : 32767));
            chk("R8 out_lo", int'(out_lo_o), s == 3 ? val : -32767);
            idle(2);
        end

        // R9 / R10 collisions at gaps 1 and 2, accept at gap 3
        wr(1, 32'd5);
        chk("R9 first accepted", int'(collide_o), 0);
        wr(1, 32'd2);
        chk("R9 gap1 collide", int'(collide_o), 1);
        chk("R10 clr kept", int'(clr_o), 5);
        wr(2, 32'd2);
        chk("R9 gap2 collide", int'(collide_o), 1);
        chk("R10 iq kept", int'(i_en_o), 1);
        wr(2, 32'd2);
        chk("R10 gap3 accepted", int'(collide_o), 0);
        chk("R10 i_en written", int'(i_en_o), 0);
        chk("R10 q_en written", int'(q_en_o), 1);
        idle(1);
        chk("R9 pulse gone", int'(collide_o), 0);
        idle(1);

        // R10 dropped divider write leaves strobe untouched
        wr(6, 32'd0);
        wr(0, 32'h0000_0005);
        chk("R10 div kept", int'(div_o), 0);
        chk("R10 stb kept", int'(spline_stb_o), 1);
        idle(2);

        // R11 unmapped address
        wr(7, 32'hFFFF_FFFF);
        chk("R11 no collide", int'(collide_o), 0);
        chk("R11 clr", int'(clr_o), 5);
        chk("R11 div", int'(div_o), 0);
        chk("R11 out_lo", int'(out_lo_o), 0);
        wr(1, 32'd3);
        chk("R11 window not opened", int'(collide_o), 0);
        chk("R11 follow-up write", int'(clr_o), 3);
        idle(2);

        // R3 / R4 / R5 divider and counter-load sweep
        for (int d = 0; d < 5; d++) begin
            for (int n = 0; n < 7; n++) begin
                int mc;
                int stb_seen;
                wr(0, {16'(n), 16'(d)});
                chk("R3 div field", int'(div_o), d);
                mc = n;
                stb_seen = 0;
                for (int c = 0; c < 14; c++) begin
                    int exp_stb;
                    exp_stb = (mc >= d) ? 1 : 0;
                    if (c == 0) chk("R5 first stb", int'(spline_stb_o), exp_stb);
                    else chk("R4 stb period", int'(spline_stb_o), exp_stb);
                    stb_seen += exp_stb;
                    mc = exp_stb ? 0 : mc + 1;
                    @(negedge clk);
                end
            end
        end

        finish_run();
    end
endmodule